// File: doc/BRIEF.md
# Quad-SPI display window and pixel streamer

This block paints a rectangle on a display controller that listens on a quad-SPI link, with no processor involved. A one-cycle start pulse latches the window origin, the window size, and a fill choice. It then runs three chip-select frames, one after the other. The first frame sets the column range and the second sets the row range. The third is the memory-write command followed by every pixel of the rectangle.

The pixels come from one of two sources. In fill mode a single RGB565 colour is repeated for the whole rectangle. In stream mode the block takes pixels from a valid/ready input. Every command goes out as a 32-bit flash-style header: an opcode and then a 24-bit address with the display command in its middle byte. The header and the window frames use one data line. The pixel payload uses all four lines.

The block drives chip select, the serial clock and the four data lines from its own serializer. The serial clock runs at half the system clock. A `done` pulse marks the end of the third frame.

Top module: `qlcd_win_streamer`

## Requirements
- R1: Every frame starts with four header bytes sent MSB first on `lcd_dat[0]`, with `lcd_dat[3:1]` low. The bytes are the opcode, 0x00, the display command, and 0x00.
- R2: A run consists of exactly three frames, in this order:
  - opcode 0x02 with command 0x2A;
  - opcode 0x02 with command 0x2B;
  - opcode 0x32 with command 0x2C.
  Each frame has its own chip-select low period.
- R3: The 0x2A frame carries four single-line bytes after its header: x start high byte, x start low byte, x end high byte, x end low byte, where x end = x start + width − 1 (16-bit wrap). The 0x2B frame has the same layout for y and height.
- R4: The 0x2C frame carries width × height pixels after its header. Each pixel is sent high byte first. Each byte is sent as two nibbles on `lcd_dat[3:0]`, upper nibble first.
- R5: Each data slot is one cycle with `lcd_sck` low followed by one cycle with it high. `lcd_sck` is never high on two cycles in a row. `lcd_dat` does not change on a cycle where `lcd_sck` is high.
- R6: `lcd_cs_n` is low on every cycle where `lcd_sck` is high. Between two frames it goes high for at least one cycle.
- R7: In stream mode a pixel is taken only on a cycle where `px_valid` and `px_ready` are both high. While no pixel is offered, the frame stalls with `lcd_sck` low and `lcd_cs_n` low. No pixel is lost or repeated.
- R8: In fill mode (`fill_en` = 1) `fill_rgb` is sent for every pixel, and `px_ready` stays low.
- R9: `busy` is high from the cycle after an accepted start until the cycle of the one-cycle `done` pulse, and low after it. A start pulse that arrives while `busy` is high changes nothing in the output.
- R10: A window with a width of zero still sends all three frames. The 0x2C frame then carries its header only, and the end coordinate wraps to start − 1.
- R11: After reset `lcd_cs_n` is high, and `lcd_sck`, `busy`, `done` and `px_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to paint a window |
| win_x | input | 16 | Window column origin |
| win_y | input | 16 | Window row origin |
| win_w | input | 16 | Window width in pixels |
| win_h | input | 16 | Window height in pixels |
| fill_en | input | 1 | 1: constant colour, 0: pixel stream |
| fill_rgb | input | 16 | RGB565 fill colour |
| px_data | input | 16 | RGB565 streamed pixel |
| px_valid | input | 1 | Streamed pixel is offered |
| px_ready | output | 1 | Block takes the offered pixel this cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| lcd_cs_n | output | 1 | Display chip select, active low |
| lcd_sck | output | 1 | Serial clock |
| lcd_dat | output | 4 | Serial data lines |

## Verification
The hardest case to reach is a pixel stream that runs dry partway through the 0x2C frame. In that case the serializer drains and sits idle with chip select still low. It then has to resume on the exact next pixel, and its high and low bytes must stay paired.

The bench reaches this case by offering streamed pixels with a random, mostly-low valid probability. The stall then falls at many different points in the nibble sequence. A second start pulse is also injected in the middle of a run, with different window values, to show that the run in progress is unchanged. A zero-width window exercises the header-only third frame and the wrapped end coordinate.

// File: rtl/qlw_pkg.sv
package qlw_pkg;

    // Coordinates are 16 bits, because each window limit goes out as two bytes.
    localparam int COORD_W = 16;
    // Payload byte count: 2 * width * height.
    localparam int CNT_W   = 2 * COORD_W + 1;

    localparam logic [7:0] OP_ONE_LINE  = 8'h02;
    localparam logic [7:0] OP_FOUR_LINE = 8'h32;
    localparam logic [7:0] CMD_COLS     = 8'h2A;
    localparam logic [7:0] CMD_ROWS     = 8'h2B;
    localparam logic [7:0] CMD_MEMWR    = 8'h2C;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_HDR, SQ_PAY, SQ_DRAIN, SQ_GAP, SQ_FIN
    } seq_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       quad;
    } ser_byte_t;

    // Header byte idx of a frame: opcode, 0x00, command, 0x00.
    function automatic logic [7:0] hdr_byte(input logic [1:0] idx,
                                            input logic [7:0] op,
                                            input logic [7:0] cmd);
        case (idx)
            2'd0:    return op;
            2'd2:    return cmd;
            default: return 8'h00;
        endcase
    endfunction

    // Window payload byte idx: start high, start low, end high, end low.
    function automatic logic [7:0] win_byte(input logic [1:0] idx,
                                            input logic [COORD_W-1:0] s,
                                            input logic [COORD_W-1:0] e);
        case (idx)
            2'd0:    return s[15:8];
            2'd1:    return s[7:0];
            2'd2:    return e[15:8];
            default: return e[7:0];
        endcase
    endfunction

    function automatic logic [7:0] frame_cmd(input logic [1:0] xf);
        case (xf)
            2'd0:    return CMD_COLS;
            2'd1:    return CMD_ROWS;
            default: return CMD_MEMWR;
        endcase
    endfunction

endpackage

// File: rtl/qlw_serializer.sv
module qlw_serializer
    import qlw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  ser_byte_t in_byte,
    output logic      in_ready,
    output logic      active,
    output logic      sck,
    output logic [3:0] dout
);
    logic [7:0] sh;
    logic       quad;
    logic [3:0] units_left;
    logic       phase;
    logic       act;
    logic       last_unit;

    assign last_unit = (units_left == 4'd1);
    // Take a new byte when idle, or on the high half of the final slot.
    // This keeps back-to-back bytes free of gaps.
    assign in_ready  = !act || (phase && last_unit);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh         <= '0;
            quad       <= 1'b0;
            units_left <= '0;
            phase      <= 1'b0;
            act        <= 1'b0;
        end else if (in_valid && in_ready) begin
            act        <= 1'b1;
            phase      <= 1'b0;
            sh         <= in_byte.data;
            quad       <= in_byte.quad;
            units_left <= in_byte.quad ? 4'd2 : 4'd8;
        end else if (act) begin
            if (!phase) begin
                phase <= 1'b1;
            end else begin
                phase <= 1'b0;
                if (last_unit) begin
                    act <= 1'b0;
                end else begin
                    units_left <= units_left - 4'd1;
                    sh <= quad ? {sh[3:0], 4'h0} : {sh[6:0], 1'b0};
                end
            end
        end
    end

    assign active = act;
    assign sck    = act && phase;
    assign dout   = quad ? sh[7:4] : {3'b000, sh[7]};

endmodule

// File: rtl/qlw_sequencer.sv
module qlw_sequencer
    import qlw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [COORD_W-1:0] win_x,
    input  logic [COORD_W-1:0] win_y,
    input  logic [COORD_W-1:0] win_w,
    input  logic [COORD_W-1:0] win_h,
    input  logic               fill_en,
    input  logic [15:0]        fill_rgb,
    input  logic [15:0]        px_data,
    input  logic               px_valid,
    output logic               px_ready,
    input  logic               ser_ready,
    input  logic               ser_active,
    output logic               ser_valid,
    output ser_byte_t          ser_byte,
    output logic               cs_n,
    output logic               busy,
    output logic               done
);
    seq_state_e         state;
    logic [1:0]         xf;
    logic [1:0]         idx;
    logic [CNT_W-1:0]   left;
    logic               lo_half;
    logic [7:0]         px_lo;
    logic [COORD_W-1:0] x_l, y_l, w_l, h_l;
    logic               fill_l;
    logic [15:0]        rgb_l;

    logic [COORD_W-1:0] x_end, y_end;
    logic [CNT_W-1:0]   pix_bytes;
    logic [15:0]        cur_px;
    logic               accept;
    logic               memwr;

    assign x_end     = x_l + w_l - COORD_W'(1);
    assign y_end     = y_l + h_l - COORD_W'(1);
    assign pix_bytes = (CNT_W'(w_l) * CNT_W'(h_l)) << 1;
    assign cur_px    = fill_l ? rgb_l : px_data;
    assign memwr     = (xf == 2'd2);

    always_comb begin
        ser_valid = 1'b0;
        ser_byte  = '{data: 8'h00, quad: 1'b0};
        if (state == SQ_HDR) begin
            ser_valid = 1'b1;
            ser_byte  = '{data: hdr_byte(idx, memwr ? OP_FOUR_LINE : OP_ONE_LINE,
                                         frame_cmd(xf)), quad: 1'b0};
        end else if (state == SQ_PAY && !memwr) begin
            ser_valid = 1'b1;
            ser_byte  = '{data: (xf == 2'd0) ? win_byte(idx, x_l, x_end)
                                             : win_byte(idx, y_l, y_end),
                          quad: 1'b0};
        end else if (state == SQ_PAY) begin
            ser_valid = lo_half || fill_l || px_valid;
            ser_byte  = '{data: lo_half ? px_lo : cur_px[15:8], quad: 1'b1};
        end
    end

    assign px_ready = (state == SQ_PAY) && memwr && !lo_half && !fill_l && ser_ready;
    assign accept   = ser_valid && ser_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            xf      <= '0;
            idx     <= '0;
            left    <= '0;
            lo_half <= 1'b0;
            px_lo   <= '0;
            x_l     <= '0;
            y_l     <= '0;
            w_l     <= '0;
            h_l     <= '0;
            fill_l  <= 1'b0;
            rgb_l   <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (start) begin
                    x_l    <= win_x;
                    y_l    <= win_y;
                    w_l    <= win_w;
                    h_l    <= win_h;
                    fill_l <= fill_en;
                    rgb_l  <= fill_rgb;
                    xf     <= 2'd0;
                    idx    <= 2'd0;
                    state  <= SQ_HDR;
                end
                SQ_HDR: if (accept) begin
                    idx <= idx + 2'd1;
                    if (idx == 2'd3) begin
                        lo_half <= 1'b0;
                        left    <= memwr ? pix_bytes : CNT_W'(4);
                        state   <= (memwr && pix_bytes == '0) ? SQ_DRAIN : SQ_PAY;
                    end
                end
                SQ_PAY: if (accept) begin
                    idx  <= idx + 2'd1;
                    left <= left - CNT_W'(1);
                    if (memwr) begin
                        lo_half <= !lo_half;
                        if (!lo_half) px_lo <= cur_px[7:0];
                    end
                    if (left == CNT_W'(1)) state <= SQ_DRAIN;
                end
                SQ_DRAIN: if (!ser_active) state <= SQ_GAP;
                SQ_GAP: begin
                    if (memwr) begin
                        state <= SQ_FIN;
                    end else begin
                        xf    <= xf + 2'd1;
                        idx   <= 2'd0;
                        state <= SQ_HDR;
                    end
                end
                SQ_FIN:  state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign cs_n = !(state == SQ_HDR || state == SQ_PAY || state == SQ_DRAIN);
    assign busy = (state != SQ_IDLE);
    assign done = (state == SQ_FIN);

endmodule

// File: rtl/qlcd_win_streamer.sv
module qlcd_win_streamer
    import qlw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [15:0] win_x,
    input  logic [15:0] win_y,
    input  logic [15:0] win_w,
    input  logic [15:0] win_h,
    input  logic        fill_en,
    input  logic [15:0] fill_rgb,
    input  logic [15:0] px_data,
    input  logic        px_valid,
    output logic        px_ready,
    output logic        busy,
    output logic        done,
    output logic        lcd_cs_n,
    output logic        lcd_sck,
    output logic [3:0]  lcd_dat
);
    logic      ser_valid;
    logic      ser_ready;
    logic      ser_active;
    ser_byte_t ser_byte;

    qlw_sequencer seq_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .win_x      (win_x),
        .win_y      (win_y),
        .win_w      (win_w),
        .win_h      (win_h),
        .fill_en    (fill_en),
        .fill_rgb   (fill_rgb),
        .px_data    (px_data),
        .px_valid   (px_valid),
        .px_ready   (px_ready),
        .ser_ready  (ser_ready),
        .ser_active (ser_active),
        .ser_valid  (ser_valid),
        .ser_byte   (ser_byte),
        .cs_n       (lcd_cs_n),
        .busy       (busy),
        .done       (done)
    );

    qlw_serializer ser_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (ser_valid),
        .in_byte  (ser_byte),
        .in_ready (ser_ready),
        .active   (ser_active),
        .sck      (lcd_sck),
        .dout     (lcd_dat)
    );

endmodule

// File: rtl/qlcd_win_streamer_chk.sv
module qlcd_win_streamer_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       px_ready,
    input logic       lcd_cs_n,
    input logic       lcd_sck,
    input logic [3:0] lcd_dat
);
    // R5
    sck_single_high_chk: assert property (@(posedge clk) disable iff (rst)
        lcd_sck |=> !lcd_sck);

    // R5
    dat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        lcd_sck |-> $stable(lcd_dat));

    // R6
    cs_frames_sck_chk: assert property (@(posedge clk) disable iff (rst)
        lcd_cs_n |-> !lcd_sck);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

    // R7
    ready_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        px_ready |-> busy);

endmodule

bind qlcd_win_streamer qlcd_win_streamer_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .px_ready (px_ready),
    .lcd_cs_n (lcd_cs_n),
    .lcd_sck  (lcd_sck),
    .lcd_dat  (lcd_dat)
);

// File: tb/qlcd_win_streamer_tb_top.sv
`timescale 1ns/1ps
module qlcd_win_streamer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] win_x = '0, win_y = '0, win_w = '0, win_h = '0;
    logic        fill_en = 1'b0;
    logic [15:0] fill_rgb = '0;
    logic [15:0] px_data = '0;
    logic        px_valid = 1'b0;
    logic        px_ready, busy, done, lcd_cs_n, lcd_sck;
    logic [3:0]  lcd_dat;

    always #10 clk = ~clk;

    qlcd_win_streamer dut_i (
        .clk(clk), .rst(rst), .start(start),
        .win_x(win_x), .win_y(win_y), .win_w(win_w), .win_h(win_h),
        .fill_en(fill_en), .fill_rgb(fill_rgb),
        .px_data(px_data), .px_valid(px_valid), .px_ready(px_ready),
        .busy(busy), .done(done),
        .lcd_cs_n(lcd_cs_n), .lcd_sck(lcd_sck), .lcd_dat(lcd_dat)
    );

    typedef struct {
        logic [3:0] v;
        string      tag;
    } unit_t;

    unit_t       exp_u[$];
    int          exp_frames[$];
    string       frame_tags[$];
    logic [15:0] pix_src[$];
    int          n_chk = 0, n_fail = 0;
    int          cycles = 0;
    int          vprob = 100;
    bit          drive_en = 1'b0;
    bit          mon_en = 1'b0;
    bit          ready_seen = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int push_byte(input logic [7:0] b, input bit quad, input string tag);
        if (quad) begin
            exp_u.push_back('{b[7:4], tag});
            exp_u.push_back('{b[3:0], tag});
            return 2;
        end
        for (int i = 7; i >= 0; i--) exp_u.push_back('{{3'b000, b[i]}, tag});
        return 8;
    endfunction

    function automatic int push_hdr(input logic [7:0] op, input logic [7:0] cmd);
        int n;
        n = push_byte(op, 0, "R1");
        n += push_byte(8'h00, 0, "R1");
        n += push_byte(cmd, 0, "R2");
        n += push_byte(8'h00, 0, "R1");
        return n;
    endfunction

    function automatic int push_win(input logic [15:0] s, input logic [15:0] sz, input string tag);
        logic [15:0] e;
        int n;
        e = s + sz - 16'd1;
        n = push_byte(s[15:8], 0, tag);
        n += push_byte(s[7:0], 0, tag);
        n += push_byte(e[15:8], 0, tag);
        n += push_byte(e[7:0], 0, tag);
        return n;
    endfunction

    // Build the expected line activity for one run. The pixel list is given
    // in px (a fill run passes the colour repeated).
    task automatic build(input logic [15:0] x, input logic [15:0] y,
                         input logic [15:0] w, input logic [15:0] h,
                         input logic [15:0] px[$], input string ptag, input string wtag);
        int n;
        n = push_hdr(8'h02, 8'h2A);
        n += push_win(x, w, wtag);
        exp_frames.push_back(n); frame_tags.push_back("R2");
        n = push_hdr(8'h02, 8'h2B);
        n += push_win(y, h, wtag);
        exp_frames.push_back(n); frame_tags.push_back("R2");
        n = push_hdr(8'h32, 8'h2C);
        foreach (px[i]) begin
            n += push_byte(px[i][15:8], 1, ptag);
            n += push_byte(px[i][7:0], 1, ptag);
        end
        exp_frames.push_back(n); frame_tags.push_back(wtag == "R10" ? "R10" : "R2");
    endtask

    // Pixel source. Valid is set at the falling edge; the handshake is
    // decided from the values that the next rising edge will see.
    always @(negedge clk) begin
        if (drive_en && pix_src.size() > 0) begin
            px_valid = (($urandom % 100) < vprob);
            px_data  = pix_src[0];
        end else begin
            px_valid = 1'b0;
        end
        #1;
        if (px_valid && px_ready) void'(pix_src.pop_front());
    end

    // Line monitor, sampled at the falling edge.
    logic       p_sck = 1'b0, p_cs = 1'b1;
    logic [3:0] p_dat = '0;
    int         units_in_frame = 0;
    always @(negedge clk) begin
        cycles++;
        if (mon_en) begin
            if (px_ready) ready_seen = 1'b1;
            if (lcd_sck && !p_sck) begin
                unit_t u;
                check(lcd_cs_n == 1'b0, "R6", "cs at sck rise", lcd_cs_n, 0);
                check(lcd_dat == p_dat, "R5", "data moved at sck rise", lcd_dat, p_dat);
                if (exp_u.size() == 0) begin
                    check(0, "R2", "extra data slot", lcd_dat, 0);
                end else begin
                    u = exp_u.pop_front();
                    check(lcd_dat == u.v, u.tag, "data slot", lcd_dat, u.v);
                end
                units_in_frame++;
            end
            if (lcd_sck && p_sck) check(0, "R5", "sck high twice", 1, 0);
            if (lcd_cs_n && !p_cs) begin
                if (exp_frames.size() == 0) begin
                    check(0, "R2", "extra frame", units_in_frame, 0);
                end else begin
                    string t;
                    int f;
                    f = exp_frames.pop_front();
                    t = frame_tags.pop_front();
                    check(units_in_frame == f, t, "slots in frame", units_in_frame, f);
                end
                units_in_frame = 0;
            end
            if (done) begin
                check(busy == 1'b1, "R9", "busy at done", busy, 1);
                check(exp_u.size() == 0, "R9", "slots left at done", exp_u.size(), 0);
            end
        end
        p_sck = lcd_sck;
        p_cs  = lcd_cs_n;
        p_dat = lcd_dat;
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic run(input logic [15:0] x, input logic [15:0] y,
                       input logic [15:0] w, input logic [15:0] h,
                       input bit fill, input logic [15:0] rgb,
                       input logic [15:0] px[$], input string ptag,
                       input string wtag, input bit poke);
        logic [15:0] q[$];
        q = px;
        build(x, y, w, h, q, ptag, wtag);
        if (!fill) pix_src = px;
        ready_seen = 1'b0;
        @(negedge clk);
        win_x = x; win_y = y; win_w = w; win_h = h;
        fill_en = fill; fill_rgb = rgb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9", "busy after start", busy, 1);
        if (poke) begin
            repeat (60) @(negedge clk);
            win_x = 16'h7777; win_w = 16'h9; fill_en = 1'b1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R9", "idle after done", {busy, done}, 0);
        check(exp_frames.size() == 0, "R2", "frames missing", exp_frames.size(), 0);
        if (fill) check(ready_seen == 1'b0, "R8", "px_ready in fill mode", ready_seen, 0);
        else check(pix_src.size() == 0, "R7", "pixels not taken", pix_src.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [15:0] px[$];
        repeat (4) @(negedge clk);
        check(lcd_cs_n == 1'b1, "R11", "cs in reset", lcd_cs_n, 1);
        check(lcd_sck == 1'b0 && busy == 1'b0 && done == 1'b0 && px_ready == 1'b0,
              "R11", "outputs in reset", {lcd_sck, busy, done, px_ready}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(lcd_cs_n == 1'b1 && busy == 1'b0, "R11", "idle after reset", {lcd_cs_n, busy}, 2);
        mon_en = 1'b1;
        drive_en = 1'b1;

        // R8: constant colour over a 2x2 window
        px = {};
        repeat (4) px.push_back(16'hA55A);
        run(16'h0003, 16'h0102, 16'd2, 16'd2, 1'b1, 16'hA55A, px, "R8", "R3", 1'b0);

        // R4: streamed 3x2 window, always valid, with an ignored start mid-run (R9)
        px = {16'h1234, 16'hF00F, 16'h8001, 16'h0000, 16'hFFFF, 16'h5AC3};
        vprob = 100;
        run(16'h0140, 16'h0010, 16'd3, 16'd2, 1'b0, 16'h0000, px, "R4", "R3", 1'b1);

        // R7: streamed 2x3 window with a sparse valid
        px = {16'hCAFE, 16'h0BAD, 16'h1357, 16'h2468, 16'h9E37, 16'h7F80};
        vprob = 25;
        run(16'h00FF, 16'h0181, 16'd2, 16'd3, 1'b0, 16'h0000, px, "R7", "R3", 1'b0);

        // R10: zero width, header-only pixel frame, wrapped end coordinate
        px = {};
        vprob = 100;
        run(16'h0000, 16'h0005, 16'd0, 16'd5, 1'b0, 16'h0000, px, "R4", "R10", 1'b0);

        finish_run();
    end

endmodule